// File: doc/BRIEF.md
# Programmable SPI serial clock generator

This block derives the serial clock of an SPI transfer engine from the system clock and provides the two timing strobes the engine needs: one that marks where a received bit is to be sampled and one that marks where the next transmit bit is to be shifted out. One configuration word sets three 6-bit fields. The divider field sets the length of a serial clock period. The high-count and low-count fields together place the rising edge inside that period, so the duty cycle can be asymmetric.

The engine raises `run` for the length of a transfer. While `run` is low the clock idles low, no strobes are issued, and the configuration word is copied into a shadow register. While `run` is high the shadow is frozen. A new setting therefore applies only from the next transfer. Each transfer begins with the low part of a period. The clock follows SPI mode 0: data is sampled on the rising edge and shifted on the falling edge.

Top module: `spi_sck_gen`

## Requirements
- R1: After a synchronous active-low reset, `sck`, `sample_stb` and `shift_stb` are all 0.
- R2: A serial clock period lasts D+1 system clocks, where D is `clk_cfg[17:12]`. A D field of 0 is treated as 1.
- R3: Let the rise point r be `clk_cfg[5:0]` minus `clk_cfg[11:6]`, clamped to the range 1 to D. Number the system clocks of a transfer k = 0, 1, 2 and so on, starting at the first clock edge at which `run` is seen high, and let the phase be k mod (D+1). `sck` is 1 when the phase is at least r and 0 otherwise, so the first period starts low.
- R4: One clock edge after `run` is seen low, `sck`, `sample_stb` and `shift_stb` are all 0. They stay 0 while `run` is low, and the next transfer restarts at phase 0.
- R5: `sample_stb` is 1 for exactly the cycles in which `sck` has just gone from 0 to 1, that is, when the phase equals r.
- R6: `shift_stb` is 1 for exactly the cycles in which `sck` has just gone from 1 to 0 inside a transfer. This is phase 0 with k > 0. No shift strobe is issued at the start of a transfer.
- R7: The configuration is captured only on clock edges at which `run` is low. A change of `clk_cfg` while `run` is high has no effect on the running transfer.
- R8: Bits of `clk_cfg` outside the three fields, including bit 31, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High for the length of a transfer |
| clk_cfg | input | 32 | Clock configuration word (divider, high-count and low-count fields) |
| sck | output | 1 | Serial clock, idles low |
| sample_stb | output | 1 | One-cycle pulse at each rising `sck` edge |
| shift_stb | output | 1 | One-cycle pulse at each falling `sck` edge inside a transfer |

## Verification
The assertions assume that `clk_cfg` matters only on clock edges at which `run` is low, and that `run` changes only between clock edges. They do not constrain the field values, because every 6-bit combination is made legal by the clamping of D and r. The stimulus drives `run` and `clk_cfg` on the falling clock edge. It holds `run` low for two cycles before each transfer so that a fresh word is captured. It also rewrites `clk_cfg` with unrelated random values partway through some transfers to show that the running transfer does not change.

// File: rtl/spi_sck_pkg.sv
// Shared field width and shadow-configuration type for the serial clock
// generator. Assumes all three configuration fields share one width.
package spi_sck_pkg;
    localparam int FIELD_W = 6;

    typedef logic [FIELD_W-1:0] fld_t;

    // Decoded, clamped timing held for the length of a transfer.
    typedef struct packed {
        fld_t div;   // last counter value of a period (at least 1)
        fld_t rise;  // counter value at which sck goes high (1..div)
    } sck_cfg_t;

    localparam sck_cfg_t CFG_RST = '{div: fld_t'(1), rise: fld_t'(1)};
endpackage

// File: rtl/spi_sck_cfg.sv
// Configuration capture: decodes the divider, high and low fields of the
// configuration word, clamps them into a legal period and rise point, and
// holds the result while a transfer runs.
// Assumes clk_cfg is only meaningful on edges where run is low.
module spi_sck_cfg
    import spi_sck_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int DIV_LSB = 12,
    parameter int HI_LSB  = 6,
    parameter int LO_LSB  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CFG_W-1:0] cfg_word,
    output sck_cfg_t         cfg_q
);
    fld_t                   div_f, hi_f, lo_f, div_eff;
    logic signed [FIELD_W:0] gap;
    sck_cfg_t               cfg_d;

    // Field decode and clamping of period and rise point.
    always_comb begin
        div_f   = cfg_word[DIV_LSB +: FIELD_W];
        hi_f    = cfg_word[HI_LSB  +: FIELD_W];
        lo_f    = cfg_word[LO_LSB  +: FIELD_W];
        div_eff = (div_f == '0) ? fld_t'(1) : div_f;
        gap     = $signed({1'b0, lo_f}) - $signed({1'b0, hi_f});
        cfg_d.div = div_eff;
        if (gap < $signed({{FIELD_W{1'b0}}, 1'b1}))
            cfg_d.rise = fld_t'(1);
        else if (gap > $signed({1'b0, div_eff}))
            cfg_d.rise = div_eff;
        else
            cfg_d.rise = gap[FIELD_W-1:0];
    end

    // Shadow register: follows the word while idle, frozen while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RST;
        else if (!run)
            cfg_q <= cfg_d;
    end

    // R7: settings do not move during a transfer.
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(cfg_q));

    // R2: the captured period is never zero and the rise point stays inside it.
    a_r2_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.div != '0) && (cfg_q.rise != '0) && (cfg_q.rise <= cfg_q.div));
endmodule

// File: rtl/spi_sck_cnt.sv
// Period counter: counts system clocks from 0 up to the captured divider
// value and wraps. It holds 0 while idle, so each transfer starts at phase 0.
// Assumes div is stable while run is high.
module spi_sck_cnt
    import spi_sck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  fld_t div,
    output fld_t cnt_nxt
);
    fld_t cnt_q;
    logic active_q;

    // Next phase: 0 on the first running cycle, then count with a wrap.
    always_comb begin
        if (!run || !active_q)
            cnt_nxt = '0;
        else if (cnt_q >= div)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_q + fld_t'(1);
    end

    // Counter and transfer-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_nxt;
            active_q <= run;
        end
    end

    // R2: the phase never passes the divider value.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= div));

    // R2: at the end of a period the counter returns to 0.
    a_r2_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && (cnt_q == div)) |=> (cnt_q == '0));

    // R4: a transfer always starts from phase 0.
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q) |=> (cnt_q == '0));
endmodule

// File: rtl/spi_sck_out.sv
// Output stage: registers the serial clock from the next phase and produces
// the sample strobe on each rising edge and the shift strobe on each falling
// edge. Assumes rise lies in 1..div, so phase 0 is always low.
module spi_sck_out
    import spi_sck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  fld_t cnt_nxt,
    input  fld_t rise,
    output logic sck,
    output logic sample_stb,
    output logic shift_stb
);
    logic sck_d;

    // Level of the serial clock in the coming cycle.
    always_comb sck_d = run && (cnt_nxt >= rise);

    // Registered clock and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck        <= 1'b0;
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end else begin
            sck        <= sck_d;
            sample_stb <= sck_d && !sck;
            shift_stb  <= run && !sck_d && sck;
        end
    end

    // R4: an idle request silences the clock and both strobes.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sck && !sample_stb && !shift_stb));

    // R5: a sample strobe marks a fresh rising edge.
    a_r5_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (sck && !$past(sck)));

    // R5: every rising edge carries a sample strobe.
    a_r5_rise_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> sample_stb);

    // R6: a shift strobe marks a fresh falling edge.
    a_r6_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> (!sck && $past(sck)));

    // R5, R6: the two strobes never coincide.
    a_r6_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb));
endmodule

// File: rtl/spi_sck_gen.sv
// Programmable SPI serial clock generator top: configuration capture,
// period counter and output stage. Assumes run is synchronous to clk and
// that clock source selection happens outside this block.
module spi_sck_gen
    import spi_sck_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int DIV_LSB = 12,
    parameter int HI_LSB  = 6,
    parameter int LO_LSB  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CFG_W-1:0] clk_cfg,
    output logic             sck,
    output logic             sample_stb,
    output logic             shift_stb
);
    sck_cfg_t cfg_q;
    fld_t     cnt_nxt;

    spi_sck_cfg #(
        .CFG_W  (CFG_W),
        .DIV_LSB(DIV_LSB),
        .HI_LSB (HI_LSB),
        .LO_LSB (LO_LSB)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cfg_word(clk_cfg),
        .cfg_q   (cfg_q)
    );

    spi_sck_cnt u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div    (cfg_q.div),
        .cnt_nxt(cnt_nxt)
    );

    spi_sck_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cnt_nxt   (cnt_nxt),
        .rise      (cfg_q.rise),
        .sck       (sck),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb)
    );
endmodule

// File: tb/spi_sck_gen_bench.sv
// Self-checking bench: directed corner cases plus seeded random transfers,
// compared against a phase model computed from the requirements.
module spi_sck_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] clk_cfg = '0;
    logic        sck, sample_stb, shift_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    spi_sck_gen u_spi_sck_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clk_cfg   (clk_cfg),
        .sck       (sck),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb)
    );

    // Model of the effective period end (R2).
    function automatic int model_div(input logic [31:0] w);
        int d = int'(w[17:12]);
        return (d == 0) ? 1 : d;
    endfunction

    // Model of the rise point (R3).
    function automatic int model_rise(input logic [31:0] w);
        int d = model_div(w);
        int r = int'(w[5:0]) - int'(w[11:6]);
        if (r < 1) r = 1;
        if (r > d) r = d;
        return r;
    endfunction

    task automatic check(input string tag, input string lbl, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b (cycle %0d)", tag, lbl, got, exp, cycles);
        end
    endtask

    // Idle for two cycles with a new word, run n cycles, optionally
    // overwrite the word mid-transfer at cycle chg_k, then drop run.
    task automatic xfer(input logic [31:0] w, input int n, input int chg_k,
                        input logic [31:0] w2, input string lbl);
        int d = model_div(w);
        int r = model_rise(w);
        run     = 1'b0;
        clk_cfg = w;
        @(negedge clk);
        check("R4", lbl, sck, 1'b0);
        check("R4", lbl, sample_stb | shift_stb, 1'b0);
        @(negedge clk);
        run = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R3 (R2 period)", lbl, sck, ((k % (d + 1)) >= r));
            check("R5", lbl, sample_stb, ((k % (d + 1)) == r));
            check("R6", lbl, shift_stb, ((k % (d + 1)) == 0) && (k > 0));
            if (k == chg_k) clk_cfg = w2;
        end
        run = 1'b0;
        @(negedge clk);
        check("R4", lbl, sck, 1'b0);
        check("R4", lbl, sample_stb, 1'b0);
        check("R4", lbl, shift_stb, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "reset", sck, 1'b0);
        check("R1", "reset", sample_stb, 1'b0);
        check("R1", "reset", shift_stb, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "after reset", sck | sample_stb | shift_stb, 1'b0);

        // R2 div zero: period of 2, rise point 1.
        xfer(32'h0000_0000, 12, -1, '0, "R2 div zero");
        // Divider 3, low 3, high 1: rise at 2, two high cycles.
        xfer({14'd0, 6'd3, 6'd1, 6'd3}, 20, -1, '0, "R3 div3");
        // Slowest setting: divider 63, low 63, high 31.
        xfer({14'd0, 6'd63, 6'd31, 6'd63}, 200, -1, '0, "R3 div63");
        // Low below high: rise clamps to 1.
        xfer({14'd0, 6'd5, 6'd9, 6'd2}, 30, -1, '0, "R3 clamp low");
        // Low minus high beyond divider: rise clamps to D.
        xfer({14'd0, 6'd4, 6'd0, 6'd40}, 25, -1, '0, "R3 clamp high");
        // R7 mid change: word rewritten during the run is ignored.
        xfer({14'd0, 6'd6, 6'd2, 6'd6}, 40, 9, {14'd0, 6'd1, 6'd0, 6'd1}, "R7 mid change");
        // R8 upper bits: source bit and unused bits set.
        xfer({1'b1, 13'h1fff, 6'd6, 6'd2, 6'd6}, 30, -1, '0, "R8 upper bits");
        // R4 drop while high: run ends in the high phase.
        xfer({14'd0, 6'd7, 6'd3, 6'd7}, 6, -1, '0, "R4 drop high");

        for (int t = 0; t < 30; t++) begin
            logic [31:0] w = $urandom;
            int n = (model_div(w) + 1) * 2 + int'($urandom % 7);
            int ck = ((t % 3) == 0) ? int'($urandom % n) : -1;
            xfer(w, n, ck, $urandom, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule